// File: doc/BRIEF.md
# Multi-Channel DMA Control Register File

This block is the register-mapped control and interrupt front end of a DMA engine with up to sixteen channels. A host reaches it through a simple word-addressed read/write port. Each channel has four window registers (start address, line length, line count, control), a stride register, and a share of three global bit-per-channel registers: abort, interrupt status and interrupt enable. A fourth global register holds two loop bits per channel. The settings leave the block on flat configuration buses that feed the address generators. The address generators and data movers are not part of this block.

A channel is launched by writing its start-address register, so software programs the other registers first and writes the address last. That write makes a one-cycle start pulse. The data path reports the end of a transfer with a one-cycle completion pulse per channel. Completions collect in a write-one-to-clear status register. Each status bit is gated by its enable bit, and the gated bits are ORed into one interrupt line.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, every register reads zero, and `ch_start`, `ch_abort`, `loop_mode`, `irq` and `bus_rdata` are all zero.
- R2: Channel n owns word addresses 4n to 4n+3. Word 4n is the 32-bit start address. Word 4n+1 is the line length and word 4n+2 is the line count, each LEN_W bits wide and zero-extended on read. Word 4n+3 is the control register: bits [3:0] hold the channel tag, bit 4 the burst flag and bit 5 the direction flag. The control register stores only bits [5:0].
- R3: The stride of channel n is LEN_W bits wide at word 0x40+n (byte 0x100+4n).
- R4: A write to the start-address word of channel n makes `ch_start[n]` high for exactly the one cycle after the write. No other write produces a start.
- R5: A write to word 0x50 (byte 0x140) makes `ch_abort[n]` high for one cycle after the write, for every data bit n that is 1. This word reads as zero.
- R6: A high `ch_done[n]` in a cycle sets status bit n at the next clock edge. The status register is at word 0x51 (byte 0x144), bit n for channel n.
- R7: A 1 written to a status bit clears it, and a 0 leaves it unchanged. When a completion and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: The enable register is at word 0x52 (byte 0x148). `irq` is high exactly when some channel has both its status bit and its enable bit set, and it follows the registers with no further delay.
- R9: The loop register is at word 0x54 (byte 0x150). For channel n only bits n and n+16 are stored, and `loop_mode[n]` is high only when both are 1.
- R10: Reads of unmapped word addresses (for example 0x53, 0x55, 0x3FF) return zero, and writes to them change no register.
- R11: Read data is registered. `bus_rdata` takes the addressed value at the edge where `bus_rd` is sampled high, and holds it while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_waddr | input | ADDR_W | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_start | output | NUM_CH | One-cycle launch pulse per channel |
| ch_abort | output | NUM_CH | One-cycle stop pulse per channel |
| ch_done | input | NUM_CH | Completion pulse per channel |
| loop_mode | output | NUM_CH | Channel runs in loop mode |
| irq | output | 1 | Combined interrupt |
| cfg_addr | output | NUM_CH*32 | Start addresses, channel n in slice n |
| cfg_len | output | NUM_CH*LEN_W | Line lengths |
| cfg_cnt | output | NUM_CH*LEN_W | Line counts |
| cfg_ctrl | output | NUM_CH*6 | Control fields |
| cfg_stride | output | NUM_CH*LEN_W | Strides |

## Verification
A completion pulse from the data path and a host write-one-to-clear to the status register can arrive in the same cycle. The bench forces this by driving `ch_done` for one channel during the same cycle as a status write. That write clears both that channel's bit and a second bit that is already set. A readback must show the contested bit still set and the other bit cleared, and `irq` must follow the enable mask.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int unsigned CTRL_W    = 6;
    localparam int unsigned WO_STRIDE = 32'h40;
    localparam int unsigned WO_ABORT  = 32'h50;
    localparam int unsigned WO_STS    = 32'h51;
    localparam int unsigned WO_EN     = 32'h52;
    localparam int unsigned WO_LOOP   = 32'h54;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic     win;
        logic     stride;
        logic     abort;
        logic     sts;
        logic     en;
        logic     loop;
        win_sel_e sel;
        logic [3:0] idx;
    } dec_t;
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] waddr,
    output dec_t              dec
);
    localparam int unsigned WIN_WORDS = NUM_CH * 4;

    logic [31:0] wa;

    always_comb begin
        wa         = 32'(waddr);
        dec        = '0;
        dec.win    = wa < WIN_WORDS;
        dec.stride = (wa >= WO_STRIDE) && (wa < WO_STRIDE + NUM_CH);
        dec.abort  = wa == WO_ABORT;
        dec.sts    = wa == WO_STS;
        dec.en     = wa == WO_EN;
        dec.loop   = wa == WO_LOOP;
        dec.sel    = win_sel_e'(wa[1:0]);
        dec.idx    = dec.win ? wa[5:2] : wa[3:0];
    end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_wr,
    input  win_sel_e          sel,
    input  logic              stride_wr,
    input  logic [31:0]       wdata,
    output logic [31:0]       addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [LEN_W-1:0]  cnt_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [LEN_W-1:0]  stride_q,
    output logic              start
);
    typedef struct packed {
        logic [31:0]       addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [CTRL_W-1:0] ctrl;
        logic [LEN_W-1:0]  stride;
        logic              start;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (win_wr) begin
            case (sel)
                SEL_ADDR: begin
                    st_d.addr  = wdata;
                    st_d.start = 1'b1;
                end
                SEL_LEN:  st_d.len  = wdata[LEN_W-1:0];
                SEL_CNT:  st_d.cnt  = wdata[LEN_W-1:0];
                SEL_CTRL: st_d.ctrl = wdata[CTRL_W-1:0];
                default:  st_d.ctrl = st_q.ctrl;
            endcase
        end
        if (stride_wr) begin
            st_d.stride = wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q   = st_q.addr;
    assign len_q    = st_q.len;
    assign cnt_q    = st_q.cnt;
    assign ctrl_q   = st_q.ctrl;
    assign stride_q = st_q.stride;
    assign start    = st_q.start;
endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] sts,
    output logic [NUM_CH-1:0] en,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] sts;
        logic [NUM_CH-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [NUM_CH-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = clr_wr ? wbits : '0;
        // a completion wins over a clear of the same bit
        st_d.sts = (st_q.sts & ~clr_mask) | done;
        if (en_wr) begin
            st_d.en = wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign irq = |(st_q.sts & st_q.en);
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LEN_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_waddr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_CH-1:0]          ch_start,
    output logic [NUM_CH-1:0]          ch_abort,
    input  logic [NUM_CH-1:0]          ch_done,
    output logic [NUM_CH-1:0]          loop_mode,
    output logic                       irq,
    output logic [NUM_CH*32-1:0]       cfg_addr,
    output logic [NUM_CH*LEN_W-1:0]    cfg_len,
    output logic [NUM_CH*LEN_W-1:0]    cfg_cnt,
    output logic [NUM_CH*CTRL_W-1:0]   cfg_ctrl,
    output logic [NUM_CH*LEN_W-1:0]    cfg_stride
);
    localparam int unsigned CH_W = $clog2(NUM_CH);

    dec_t dec;

    logic [31:0]       a_addr   [NUM_CH];
    logic [LEN_W-1:0]  a_len    [NUM_CH];
    logic [LEN_W-1:0]  a_cnt    [NUM_CH];
    logic [CTRL_W-1:0] a_ctrl   [NUM_CH];
    logic [LEN_W-1:0]  a_stride [NUM_CH];
    logic [NUM_CH-1:0] irq_sts;
    logic [NUM_CH-1:0] irq_en;

    typedef struct packed {
        logic [NUM_CH-1:0] abort;
        logic [NUM_CH-1:0] lp_lo;
        logic [NUM_CH-1:0] lp_hi;
        logic [31:0]       rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [31:0]     rd_val;
    logic [CH_W-1:0] ci;

    dmac_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .waddr (bus_waddr),
        .dec   (dec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dmac_chan_regs #(.LEN_W(LEN_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .win_wr    (bus_wr && dec.win && (dec.idx == 4'(i))),
            .sel       (dec.sel),
            .stride_wr (bus_wr && dec.stride && (dec.idx == 4'(i))),
            .wdata     (bus_wdata),
            .addr_q    (a_addr[i]),
            .len_q     (a_len[i]),
            .cnt_q     (a_cnt[i]),
            .ctrl_q    (a_ctrl[i]),
            .stride_q  (a_stride[i]),
            .start     (ch_start[i])
        );
        assign cfg_addr[i*32 +: 32]         = a_addr[i];
        assign cfg_len[i*LEN_W +: LEN_W]    = a_len[i];
        assign cfg_cnt[i*LEN_W +: LEN_W]    = a_cnt[i];
        assign cfg_ctrl[i*CTRL_W +: CTRL_W] = a_ctrl[i];
        assign cfg_stride[i*LEN_W +: LEN_W] = a_stride[i];
    end

    dmac_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (ch_done),
        .clr_wr (bus_wr && dec.sts),
        .en_wr  (bus_wr && dec.en),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .sts    (irq_sts),
        .en     (irq_en),
        .irq    (irq)
    );

    always_comb begin
        ci     = dec.idx[CH_W-1:0];
        rd_val = '0;
        if (dec.win) begin
            case (dec.sel)
                SEL_ADDR: rd_val = a_addr[ci];
                SEL_LEN:  rd_val = 32'(a_len[ci]);
                SEL_CNT:  rd_val = 32'(a_cnt[ci]);
                SEL_CTRL: rd_val = 32'(a_ctrl[ci]);
                default:  rd_val = '0;
            endcase
        end else if (dec.stride) begin
            rd_val = 32'(a_stride[ci]);
        end else if (dec.sts) begin
            rd_val = 32'(irq_sts);
        end else if (dec.en) begin
            rd_val = 32'(irq_en);
        end else if (dec.loop) begin
            rd_val[NUM_CH-1:0]   = st_q.lp_lo;
            rd_val[16 +: NUM_CH] = st_q.lp_hi;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.abort = (bus_wr && dec.abort) ? bus_wdata[NUM_CH-1:0] : '0;
        if (bus_wr && dec.loop) begin
            st_d.lp_lo = bus_wdata[NUM_CH-1:0];
            st_d.lp_hi = bus_wdata[16 +: NUM_CH];
        end
        if (bus_rd) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_abort  = st_q.abort;
    assign loop_mode = st_q.lp_lo & st_q.lp_hi;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_waddr,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_abort,
    input logic [NUM_CH-1:0] ch_done,
    input logic              irq,
    input logic [NUM_CH-1:0] sts,
    input logic [NUM_CH-1:0] loop_mode
);
    localparam logic [ADDR_W-1:0] A_ABORT = ADDR_W'(32'h50);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(32'h52);
    localparam logic [ADDR_W-1:0] A_LOOP  = ADDR_W'(32'h54);
    localparam logic [ADDR_W-1:0] A_WEND  = ADDR_W'(NUM_CH * 4);

    p_start_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> $past(bus_wr && (bus_waddr < A_WEND) && (bus_waddr[1:0] == 2'b00)));

    p_abort_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_abort != '0) |-> $past(bus_wr && (bus_waddr == A_ABORT)));

    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> ((sts & $past(ch_done)) == $past(ch_done)));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((ch_done != '0) || (bus_wr && (bus_waddr == A_EN))));

    p_loop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_waddr == A_LOOP)) |=> $stable(loop_mode));
endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_waddr (bus_waddr),
    .ch_start  (ch_start),
    .ch_abort  (ch_abort),
    .ch_done   (ch_done),
    .irq       (irq),
    .sts       (irq_sts),
    .loop_mode (loop_mode)
);

// File: tb/test_dmac_regfile.sv
`timescale 1ns/1ps
module test_dmac_regfile;
    localparam int NUM_CH = 16;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_CH-1:0] ch_start, ch_abort, loop_mode;
    logic [NUM_CH-1:0] ch_done = '0;
    logic irq;
    logic [NUM_CH*32-1:0] cfg_addr;
    logic [NUM_CH*LEN_W-1:0] cfg_len, cfg_cnt, cfg_stride;
    logic [NUM_CH*6-1:0] cfg_ctrl;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    dmac_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dmac_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_start(ch_start), .ch_abort(ch_abort), .ch_done(ch_done),
        .loop_mode(loop_mode), .irq(irq), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .cfg_cnt(cfg_cnt), .cfg_ctrl(cfg_ctrl), .cfg_stride(cfg_stride)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // monitor: pops the scoreboard one cycle after each sampled read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(int w, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = ADDR_W'(w); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int w, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_waddr = ADDR_W'(w);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 start", 32'(ch_start), 0);
        chk("R1 abort", 32'(ch_abort), 0);
        chk("R1 loop_mode", 32'(loop_mode), 0);
        chk("R1 rdata", bus_rdata, 0);
        rst_n = 1'b1;
        bus_read(32'h51, 0, "R1 status after reset");
        bus_read(4*3, 0, "R1 ch3 addr after reset");

        // R2 window registers, no start on them (R4)
        bus_write(4*2+1, 32'h1234_5678);
        chk("R4 no start on len write", 32'(ch_start), 0);
        bus_write(4*2+2, 32'hCAFE_0042);
        bus_write(4*2+3, 32'hFFFF_FFF2);
        chk("R4 no start on ctrl write", 32'(ch_start), 0);
        bus_read(4*2+1, 32'h0000_5678, "R2 ch2 len");
        bus_read(4*2+2, 32'h0000_0042, "R2 ch2 cnt");
        bus_read(4*2+3, 32'h0000_0032, "R2 ch2 ctrl");

        // R4 start pulses
        bus_write(4*2, 32'hDEAD_BEE0);
        chk("R4 start ch2", 32'(ch_start), 32'h0004);
        @(negedge clk);
        chk("R4 start one cycle", 32'(ch_start), 0);
        bus_write(4*15, 32'h0000_1000);
        chk("R4 start ch15", 32'(ch_start), 32'h8000);
        bus_read(4*2, 32'hDEAD_BEE0, "R2 ch2 addr");
        bus_read(4*15, 32'h0000_1000, "R2 ch15 addr");

        // R3 stride
        bus_write(32'h47, 32'h000A_BCD1);
        bus_read(32'h47, 32'h0000_BCD1, "R3 ch7 stride");
        bus_read(32'h40, 0, "R3 ch0 stride");

        // R5 abort
        bus_write(32'h50, 32'h0000_8001);
        chk("R5 abort pulse", 32'(ch_abort), 32'h8001);
        @(negedge clk);
        chk("R5 abort one cycle", 32'(ch_abort), 0);
        bus_read(32'h50, 0, "R5 abort reads zero");

        // R6 completion
        @(negedge clk);
        ch_done = 16'h0024;
        @(negedge clk);
        ch_done = '0;
        chk("R8 irq masked", 32'(irq), 0);
        bus_read(32'h51, 32'h24, "R6 status set");

        // R8 enable
        bus_write(32'h52, 32'h0000_0004);
        chk("R8 irq on", 32'(irq), 1);
        // R7 clear
        bus_write(32'h51, 32'h0000_0004);
        chk("R8 irq off after clear", 32'(irq), 0);
        bus_read(32'h51, 32'h20, "R7 status after clear");

        // R7 completion and clear on the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = ADDR_W'(32'h51); bus_wdata = 32'h28;
        ch_done = 16'h0008;
        @(negedge clk);
        bus_wr = 1'b0; ch_done = '0;
        chk("R7 same-cycle irq", 32'(irq), 0);
        bus_read(32'h51, 32'h08, "R7 same-cycle status");

        // R9 loop
        bus_write(32'h54, 32'hFFFF_FFFF);
        chk("R9 loop all", 32'(loop_mode), 32'hFFFF);
        bus_read(32'h54, 32'hFFFF_FFFF, "R9 loop read all");
        bus_write(32'h54, 32'h0001_0003);
        chk("R9 loop one", 32'(loop_mode), 32'h0001);
        bus_read(32'h54, 32'h0001_0003, "R9 loop read");

        // R10 unmapped
        bus_write(32'h53, 32'hFFFF_FFFF);
        bus_write(32'h55, 32'hFFFF_FFFF);
        bus_write(32'h3FF, 32'hFFFF_FFFF);
        chk("R10 no start", 32'(ch_start), 0);
        bus_read(32'h53, 0, "R10 read 0x53");
        bus_read(32'h3FF, 0, "R10 read 0x3FF");
        bus_read(32'h52, 32'h4, "R10 enable intact");
        bus_read(32'h51, 32'h08, "R10 status intact");
        chk("R10 loop intact", 32'(loop_mode), 32'h0001);

        // R11 hold
        repeat (3) @(negedge clk);
        chk("R11 rdata held", bus_rdata, 32'h08);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 0);
        report();
        $finish;
    end
endmodule